// File: doc/BRIEF.md
# Skipping Round-Robin Port Selector

This block decides which of several receive ports hands its next complete packet to a single shared reader. Each port raises a flag while it holds at least one whole packet. The selector walks the ports in a fixed rotating order and passes over any port without a complete packet. It presents the chosen port number together with an available flag. The reader drains the packet and then pulses a done input. The reader can instead pulse a skip input to abandon the current port in the middle of a read.

After a done, the selector moves straight to the next ready port with no idle cycle between packets. After a skip, the available flag always drops for exactly one cycle before a port is offered again. This lets the reader see a clean break between two ports. The search always begins at the port after the one most recently offered, and the port just left is considered last. The packet buffers and the data path belong to the surrounding logic.

Top module: `rr_skip_sel`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, `avail` is 0 and `port` reads NPORTS-1, so the first search begins at port 0.
- R2: A search starts at `port`+1 and runs upward, wrapping from NPORTS-1 to 0. The port just offered is examined last. The first port whose `ready` bit is 1 is chosen.
- R3: When `avail` is 0 and at least one `ready` bit is 1, `avail` is 1 on the next cycle and `port` shows the port chosen by R2.
- R4: A `done` pulse while `avail` is 1, with at least one `ready` bit set, keeps `avail` at 1 on the next cycle and loads `port` with the R2 choice.
- R5: A `done` pulse while `avail` is 1, with no `ready` bit set, makes `avail` 0 on the next cycle and leaves `port` unchanged.
- R6: A `skip` pulse while `avail` is 1 (without `done`) makes `avail` 0 for exactly one cycle with `port` unchanged. On the cycle after that, R3 applies with the search starting after the skipped port.
- R7: While `avail` is 1 and neither `done` nor `skip` is pulsed, `avail` stays 1 and `port` does not change, whatever `ready` does.
- R8: While `avail` is 0 and all `ready` bits are 0, `avail` stays 0 and `port` keeps its value.
- R9: If `done` and `skip` are both 1 in one cycle while `avail` is 1, `done` takes effect and `skip` is ignored.
- R10: `done` and `skip` have no effect while `avail` is 0. Only R3 or R8 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ready | input | NPORTS | Bit i set: port i holds a complete packet |
| done | input | 1 | One-cycle pulse: current packet fully read |
| skip | input | 1 | One-cycle pulse: leave the current port mid-read |
| port | output | $clog2(NPORTS) | Port currently offered to the reader |
| avail | output | 1 | The offered port may be read |

## Verification
The bench builds the selector with NPORTS set to 5. This is not a power of two, so the wrap from port 4 back to port 0 depends on the explicit compare-and-subtract and not on a natural counter overflow. With five ports, every nonzero ready pattern (31 of them) can be applied from every starting port, for both the done path and the skip path. Every rotation offset of the search is therefore exercised. Separate short sequences cover the hold, idle, collision and ignored-pulse cases.

// File: rtl/rr_skip_sel.sv
module rr_skip_sel #(
  parameter int NPORTS = 8,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] ready,
  input  logic              done,
  input  logic              skip,
  output logic [PW-1:0]     port,
  output logic              avail
);

  logic          hit;
  logic [PW-1:0] pick;

  always_comb begin
    logic [PW:0] k;
    hit  = 1'b0;
    pick = port;
    for (int i = 1; i <= NPORTS; i++) begin
      k = {1'b0, port} + (PW+1)'(i);
      if (k >= (PW+1)'(NPORTS)) k = k - (PW+1)'(NPORTS);
      if (!hit && ready[k[PW-1:0]]) begin
        hit  = 1'b1;
        pick = k[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail <= 1'b0;
      port  <= PW'(NPORTS-1);
    end else if (avail) begin
      if (done) begin
        avail <= hit;
        if (hit) port <= pick;
      end else if (skip) begin
        avail <= 1'b0;
      end
    end else if (hit) begin
      avail <= 1'b1;
      port  <= pick;
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && !done && !skip) |=> (avail && $stable(port)));

  // R6
  skip_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && skip && !done) |=> (!avail && $stable(port)));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && ready == '0) |=> (!avail && $stable(port)));

  // R3
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && ready != '0) |=> avail);

  // R4
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && done && ready != '0) |=> avail);

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && done && ready == '0) |=> (!avail && $stable(port)));

endmodule

// File: tb/sim_rr_skip_sel.sv
module sim_rr_skip_sel;
  localparam int CLK_P = 10;
  localparam int N  = 5;
  localparam int PW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ready = '0;
  logic done = 1'b0, skip = 1'b0;
  logic [PW-1:0] port;
  logic avail;

  int n_cmp = 0, n_bad = 0;
  bit exp_av;
  int exp_pt;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rr_skip_sel #(.NPORTS(N)) u0 (.clk(clk), .rst_n(rst_n), .ready(ready),
    .done(done), .skip(skip), .port(port), .avail(avail));

  function automatic int nxt(int base, logic [N-1:0] pat);
    for (int i = 1; i <= N; i++)
      if (pat[(base + i) % N]) return (base + i) % N;
    return -1;
  endfunction

  task automatic check(string tag);
    n_cmp++;
    if (avail !== exp_av || int'(port) != exp_pt) begin
      n_bad++;
      $display("FAIL %s: avail=%0b port=%0d expected avail=%0b port=%0d",
               tag, avail, port, exp_av, exp_pt);
    end
  endtask

  task automatic step(logic [N-1:0] r, bit d, bit s, string tag);
    int c;
    @(negedge clk);
    ready = r; done = d; skip = s;
    c = nxt(exp_pt, r);
    if (exp_av) begin
      if (d) begin
        exp_av = (c >= 0);
        if (c >= 0) exp_pt = c;
      end else if (s) exp_av = 1'b0;
    end else if (c >= 0) begin
      exp_av = 1'b1;
      exp_pt = c;
    end
    @(posedge clk); #1;
    check(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    exp_av = 1'b0; exp_pt = N-1;
    check("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release");
    step('0, 1'b0, 1'b0, "R8 idle");
    step('1, 1'b0, 1'b0, "R1 R3 first grant is port 0");
    step('0, 1'b1, 1'b0, "R5 drain");

    for (int s = 0; s < N; s++) begin
      for (int p = 1; p < (1 << N); p++) begin
        step(N'(1) << s, 1'b0, 1'b0, "R3 grant start");
        step(N'(p), 1'b1, 1'b0, "R2 R4 done to next");
        step('0, 1'b0, 1'b0, "R7 hold");
        step('0, 1'b1, 1'b0, "R5 done empty");
        step(N'(1) << s, 1'b0, 1'b0, "R3 grant start");
        step(N'(p), 1'b0, 1'b1, "R6 skip gap");
        step(N'(p), 1'b0, 1'b0, "R2 R6 regrant after skip");
        step('0, 1'b1, 1'b0, "R5 done empty");
      end
    end

    step(5'b00100, 1'b0, 1'b0, "R3 grant 2");
    step(5'b11111, 1'b0, 1'b0, "R7 ready change");
    step(5'b00000, 1'b0, 1'b0, "R7 ready drop");
    step(5'b01000, 1'b1, 1'b1, "R9 done wins");
    step(5'b00000, 1'b1, 1'b1, "R9 done wins empty");
    step(5'b00000, 1'b1, 1'b0, "R10 done ignored");
    step(5'b00000, 1'b0, 1'b1, "R10 skip ignored");
    step(5'b00001, 1'b0, 1'b1, "R10 skip while low");
    step(5'b00000, 1'b1, 1'b0, "R5 drain");
    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: finished=0 expected finished=1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule